// File: doc/BRIEF.md
# Trace Start/Stop Resource

This block keeps the single "trace on" state that lets watchpoint comparator hits open and close a tracing window. Four watchpoint match lines come in. A selection register marks each line as a start source, a stop source, both, or neither. A start hit sets the state and a stop hit clears it. The state stays where it is until the next selected hit, a software write, or reset.

A separate control register holds an enable bit. That bit decides whether the state actually gates tracing. When the bit is off, the trace-enable qualifier stays high and the state still follows the hits. Software can read the state through the status register and can overwrite it there. While the external programming flag is high, hits are ignored.

All three registers share one write port and one combinational read port with a 2-bit register select. The select codes are: 0 for the selection register, 1 for the control register, 2 for the status register, and 3 for an unused slot that reads zero.

Top module: `trace_startstop`

## Requirements
- R1: After reset the selection register, the control register and the state are all 0, and `trace_en_o` is 1.
- R2: A hit on watchpoint input k (k = 0..3) sets the state when selection bit k is 1. The state and `state_o` show 1 from the following cycle.
- R3: A hit on watchpoint input k clears the state when selection bit 16+k is 1. `state_o` shows 0 from the following cycle.
- R4: A hit on an input whose start and stop selection bits are both 0 leaves the state unchanged.
- R5: When a start hit and a stop hit are present in the same cycle, stop wins and the state becomes 0.
- R6: With no selected hit, the state keeps its value across any number of cycles.
- R7: A write to register select 2 loads write-data bit 2 into the state. This write overrides any hit in the same cycle. A read of register select 2 returns the state in bit 2 and zero in every other bit.
- R8: While `prog_i` is 1, hits do not change the state. A software write through R7 still takes effect.
- R9: Control register bit 25 is the gating enable. When it is 0, `trace_en_o` is 1. When it is 1, `trace_en_o` equals the state.
- R10: The state follows start and stop hits whether the gating enable is 0 or 1.
- R11: The selection register stores only bits 3:0 and 19:16, and all other bits read as 0. The control register stores only bit 25. The unused register select 3 reads as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| wp_hit_i | input | 4 | Watchpoint match lines, bit k is input k |
| prog_i | input | 1 | Programming flag; freezes the state against hits |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 2 | Register select: 0 selection, 1 control, 2 status, 3 unused |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Read data for the register at reg_addr_i |
| state_o | output | 1 | Raw start/stop state |
| trace_en_o | output | 1 | Final trace-enable qualifier |

## Verification
The assertions check four things on every cycle. Stop beats start in the same cycle. A start alone sets the state. The programming flag freezes the state. A status write lands in the state one cycle later. The assertions also check that the enable bit and the reserved readback bits follow the writes.

Some behaviour only the bench scenarios can show. One case is that a hit on each of the four inputs reaches the state only through its own selection bit. Another is that the state keeps tracking hits while gating is off, and that this state appears at the qualifier once gating is turned on. Long mixed runs of writes, programming windows and hits against a reference model also cover orderings that no single property spans.

// File: rtl/trss_pkg.sv
package trss_pkg;
  localparam int unsigned REG_W = 32;
  localparam int unsigned NUM_WP = 4;
  localparam int unsigned START_LSB = 0;
  localparam int unsigned STOP_LSB = 16;
  localparam int unsigned EN_BIT = 25;
  localparam int unsigned STAT_BIT = 2;

  typedef enum logic [1:0] {
    RA_SEL  = 2'd0,
    RA_CTRL = 2'd1,
    RA_STAT = 2'd2,
    RA_NONE = 2'd3
  } reg_addr_e;
endpackage

// File: rtl/trss_regs.sv
module trss_regs #(
  parameter int unsigned NUM_WP = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sel_we_i,
  input  logic              ctrl_we_i,
  input  logic [NUM_WP-1:0] start_wdata_i,
  input  logic [NUM_WP-1:0] stop_wdata_i,
  input  logic              en_wdata_i,
  output logic [NUM_WP-1:0] start_mask_o,
  output logic [NUM_WP-1:0] stop_mask_o,
  output logic              gate_en_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      start_mask_o <= '0;
      stop_mask_o  <= '0;
    end else if (sel_we_i) begin
      start_mask_o <= start_wdata_i;
      stop_mask_o  <= stop_wdata_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        gate_en_o <= 1'b0;
    else if (ctrl_we_i) gate_en_o <= en_wdata_i;
  end

  AST_EN_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctrl_we_i |=> gate_en_o == $past(en_wdata_i)); // R9
  AST_SEL_KEEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sel_we_i |=> $stable(start_mask_o) && $stable(stop_mask_o)); // R11
endmodule

// File: rtl/trss_match.sv
module trss_match #(
  parameter int unsigned NUM_WP = 4
) (
  input  logic [NUM_WP-1:0] hit_i,
  input  logic [NUM_WP-1:0] start_mask_i,
  input  logic [NUM_WP-1:0] stop_mask_i,
  output logic              start_o,
  output logic              stop_o
);
  logic [NUM_WP-1:0] start_q, stop_q;

  for (genvar k = 0; k < NUM_WP; k++) begin : g_wp
    assign start_q[k] = hit_i[k] & start_mask_i[k];
    assign stop_q[k]  = hit_i[k] & stop_mask_i[k];
  end

  assign start_o = |start_q;
  assign stop_o  = |stop_q;

  always_comb begin
    if (hit_i == '0) AST_NO_HIT_NO_EVT: assert (!start_o && !stop_o); // R4
  end
endmodule

// File: rtl/trss_state.sv
module trss_state (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  input  logic stop_i,
  input  logic hold_i,
  input  logic sw_we_i,
  input  logic sw_val_i,
  output logic state_o
);
  logic state_d;

  always_comb begin
    state_d = state_o;
    if (sw_we_i)     state_d = sw_val_i;
    else if (hold_i) state_d = state_o;
    else if (stop_i) state_d = 1'b0;
    else if (start_i) state_d = 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_o <= 1'b0;
    else         state_o <= state_d;
  end

  AST_STOP_WINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stop_i && !hold_i && !sw_we_i) |=> !state_o); // R5
  AST_START_SETS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && !stop_i && !hold_i && !sw_we_i) |=> state_o); // R2
  AST_PROG_FREEZE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hold_i && !sw_we_i) |=> $stable(state_o)); // R8
  AST_SW_LOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sw_we_i |=> state_o == $past(sw_val_i)); // R7
  AST_IDLE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!start_i && !stop_i && !sw_we_i) |=> $stable(state_o)); // R6
endmodule

// File: rtl/trace_startstop.sv
module trace_startstop
  import trss_pkg::*;
(
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [NUM_WP-1:0]    wp_hit_i,
  input  logic                 prog_i,
  input  logic                 reg_we_i,
  input  logic [1:0]           reg_addr_i,
  input  logic [REG_W-1:0]     reg_wdata_i,
  output logic [REG_W-1:0]     reg_rdata_o,
  output logic                 state_o,
  output logic                 trace_en_o
);
  logic [NUM_WP-1:0] start_mask, stop_mask;
  logic gate_en, start_evt, stop_evt;
  logic sel_we, ctrl_we, stat_we;
  logic unused_wdata;

  assign sel_we  = reg_we_i && (reg_addr_i == RA_SEL);
  assign ctrl_we = reg_we_i && (reg_addr_i == RA_CTRL);
  assign stat_we = reg_we_i && (reg_addr_i == RA_STAT);
  assign unused_wdata = ^reg_wdata_i;

  trss_regs #(.NUM_WP(NUM_WP)) u_regs (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .sel_we_i      (sel_we),
    .ctrl_we_i     (ctrl_we),
    .start_wdata_i (reg_wdata_i[START_LSB +: NUM_WP]),
    .stop_wdata_i  (reg_wdata_i[STOP_LSB +: NUM_WP]),
    .en_wdata_i    (reg_wdata_i[EN_BIT]),
    .start_mask_o  (start_mask),
    .stop_mask_o   (stop_mask),
    .gate_en_o     (gate_en)
  );

  trss_match #(.NUM_WP(NUM_WP)) u_match (
    .hit_i        (wp_hit_i),
    .start_mask_i (start_mask),
    .stop_mask_i  (stop_mask),
    .start_o      (start_evt),
    .stop_o       (stop_evt)
  );

  trss_state u_state (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .start_i  (start_evt),
    .stop_i   (stop_evt),
    .hold_i   (prog_i),
    .sw_we_i  (stat_we),
    .sw_val_i (reg_wdata_i[STAT_BIT]),
    .state_o  (state_o)
  );

  // gating off leaves tracing unqualified by the start/stop state
  assign trace_en_o = gate_en ? state_o : 1'b1;

  always_comb begin
    reg_rdata_o = '0;
    unique case (reg_addr_i)
      RA_SEL: begin
        reg_rdata_o[START_LSB +: NUM_WP] = start_mask;
        reg_rdata_o[STOP_LSB +: NUM_WP]  = stop_mask;
      end
      RA_CTRL: reg_rdata_o[EN_BIT]   = gate_en;
      RA_STAT: reg_rdata_o[STAT_BIT] = state_o;
      default: reg_rdata_o = '0;
    endcase
  end

  AST_RESET_QUAL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(!rst_ni) |-> trace_en_o); // R1
  AST_STAT_ONLY_BIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_addr_i == RA_STAT) |-> $countones(reg_rdata_o) <= 1); // R7
  AST_SPARE_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_addr_i == RA_NONE) |-> reg_rdata_o == '0); // R11
endmodule

// File: tb/trace_startstop_test.sv
module trace_startstop_test;
  localparam int CLK_PERIOD = 10;
  localparam logic [31:0] SEL_MASK = 32'h000F_000F;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [3:0] hit = '0;
  logic prog = 1'b0, we = 1'b0;
  logic [1:0] addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic state, trace_en;

  int checks = 0, errors = 0;
  logic m_state = 1'b0, m_en = 1'b0;
  logic [31:0] m_sel = '0;

  trace_startstop uut (
    .clk_i(clk), .rst_ni(rst_n), .wp_hit_i(hit), .prog_i(prog),
    .reg_we_i(we), .reg_addr_i(addr), .reg_wdata_i(wdata),
    .reg_rdata_o(rdata), .state_o(state), .trace_en_o(trace_en)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [31:0] exp_rd(input logic [1:0] a);
    case (a)
      2'd0: return m_sel & SEL_MASK;
      2'd1: return {6'd0, m_en, 25'd0};
      2'd2: return {29'd0, m_state, 2'b00};
      default: return 32'd0;
    endcase
  endfunction

  function automatic logic exp_qual();
    return m_en ? m_state : 1'b1;
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic step(input string tag, input logic [3:0] h, input logic p,
                      input logic w, input logic [1:0] a, input logic [31:0] d);
    logic st, sp;
    @(negedge clk);
    hit = h; prog = p; we = w; addr = a; wdata = d;
    st = |(h & m_sel[3:0]);
    sp = |(h & m_sel[19:16]);
    if (w && a == 2'd2)      m_state = d[2];
    else if (!p && sp)       m_state = 1'b0;
    else if (!p && st)       m_state = 1'b1;
    if (w && a == 2'd0) m_sel = d & SEL_MASK;
    if (w && a == 2'd1) m_en = d[25];
    @(posedge clk); #1;
    chk({tag, " state"}, {31'd0, state}, {31'd0, m_state});
    chk({tag, " qual"}, {31'd0, trace_en}, {31'd0, exp_qual()});
  endtask

  task automatic rd(input string tag, input logic [1:0] a);
    @(negedge clk);
    we = 1'b0; hit = '0; addr = a; #1;
    chk(tag, rdata, exp_rd(a));
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    checks++; errors++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    repeat (3) @(negedge clk);
    #1;
    chk("R1 state", {31'd0, state}, 32'd0);
    chk("R1 qual", {31'd0, trace_en}, 32'd1);
    rst_n = 1'b1;
    rd("R1 sel", 2'd0); rd("R1 ctrl", 2'd1); rd("R1 stat", 2'd2);

    step("R11 wr sel", 4'd0, 1'b0, 1'b1, 2'd0, 32'hFFFF_FFFF);
    rd("R11 sel mask", 2'd0);
    step("R11 wr ctrl", 4'd0, 1'b0, 1'b1, 2'd1, 32'hFFFF_FFFF);
    rd("R11 ctrl mask", 2'd1);
    rd("R11 spare", 2'd3);
    step("R9 ctrl off", 4'd0, 1'b0, 1'b1, 2'd1, 32'd0);

    // each input as start then stop
    for (int k = 0; k < 4; k++) begin
      step("R2 sel", 4'd0, 1'b0, 1'b1, 2'd0, 32'h1 << k);
      step("R2 start", 4'h1 << k, 1'b0, 1'b0, 2'd0, 32'd0);
      step("R6 hold", 4'd0, 1'b0, 1'b0, 2'd0, 32'd0);
      step("R6 hold", 4'd0, 1'b0, 1'b0, 2'd0, 32'd0);
      step("R3 sel", 4'd0, 1'b0, 1'b1, 2'd0, 32'h1 << (16 + k));
      step("R3 stop", 4'h1 << k, 1'b0, 1'b0, 2'd0, 32'd0);
    end

    step("R4 sel", 4'd0, 1'b0, 1'b1, 2'd0, 32'h0002_0001);
    step("R4 set", 4'b0001, 1'b0, 1'b0, 2'd0, 32'd0);
    step("R4 unselected", 4'b1100, 1'b0, 1'b0, 2'd0, 32'd0);
    step("R5 both", 4'b0011, 1'b0, 1'b0, 2'd0, 32'd0);
    step("R8 prog start", 4'b0001, 1'b1, 1'b0, 2'd0, 32'd0);
    step("R8 prog sw", 4'b0000, 1'b1, 1'b1, 2'd2, 32'h4);
    step("R8 prog stop", 4'b0010, 1'b1, 1'b0, 2'd0, 32'd0);
    step("R7 sw over stop", 4'b0010, 1'b0, 1'b1, 2'd2, 32'h4);
    rd("R7 stat read", 2'd2);
    step("R7 sw over start", 4'b0001, 1'b0, 1'b1, 2'd2, 32'h0);
    step("R10 gate off start", 4'b0001, 1'b0, 1'b0, 2'd0, 32'd0);
    step("R9 gate on", 4'b0000, 1'b0, 1'b1, 2'd1, 32'h0200_0000);
    step("R9 gate stop", 4'b0010, 1'b0, 1'b0, 2'd0, 32'd0);
    step("R10 gate on start", 4'b0001, 1'b0, 1'b0, 2'd0, 32'd0);

    for (int i = 0; i < 3000; i++) begin
      logic p, w;
      p = ($urandom % 8) == 0;
      w = ($urandom % 4) == 0;
      step("R2/R3 random", 4'($urandom), p, w, 2'($urandom), $urandom);
      if ((i % 16) == 0) rd("R11 random read", 2'($urandom));
    end

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule